// File: doc/BRIEF.md
# BCD calendar time counter

The block keeps wall-clock time as eight bytes: seconds, minutes, hours, day of month, month, two-digit year, weekday and a century byte. All of them except the weekday are packed BCD; the weekday is a 3-bit binary count. Each pulse on the one-second tick input advances the time by one second. The carry ripples through every field in the same cycle, so month lengths, leap Februaries, the year wrap and the century carry all resolve on a single tick.

A host reads the eight bytes at once through a 64-bit window, or one byte at a time through a small read port. Byte offset k sits in window bits [8k+7:8k]. The host can also preset all eight bytes in one cycle.

The counter comes out of reset with its oscillator stopped, and it ignores ticks in that state. A preset whose eight bytes are all zero starts the oscillator. Any other preset only changes the stored time.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the window reads, from offset 7 down to offset 0, 0x20 0x00 0x00 0x01 0x01 0x80 0x00 0x00 and osc_run_o is 0. The offsets in order are seconds 0, minutes 1, hours 2, day 3, month 4, year 5, weekday 6 and century 7.
- R2: While osc_run_o is 0, ticks change nothing. A load whose 64 data bits are all zero sets osc_run_o to 1, and osc_run_o then stays 1 until reset. A load with any nonzero bit presets the time and leaves osc_run_o unchanged.
- R3: A load writes all eight bytes in the cycle after load_i. The weekday keeps only data bits 2:0, and its bits 7:3 read 0. If a load and a tick arrive in the same cycle, the load wins and the tick is dropped.
- R4: Seconds and minutes count in BCD from 00 to 59. When a field reaches 59 or more, the next tick sets it to 00 and carries into the next field. An out-of-range value therefore wraps on its first step.
- R5: Hours count 00 to 23 in BCD in bits 5:0. A step out of 23 or more sets bits 5:0 to 00 and carries into the day. Counting never changes bits 7:6 of the hour byte; bit 7 is the 24-hour flag.
- R6: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. A day wrap advances the month.
- R7: In February the day wraps after 29 when the BCD year is divisible by 4 (00, 04, …, 12, …), and after 28 otherwise.
- R8: The month counts 01 to 12. A step out of 12 sets it to 01 and advances the year.
- R9: The year counts 00 to 99. A step out of 99 sets it to 00 and increments the century byte by one in BCD.
- R10: The weekday advances each time the day field steps, and it wraps from 6 (or above) to 0.
- R11: rd_data_o shows the byte at offset rd_addr_i, decoded combinationally from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| load_i | input | 1 | Preset strobe |
| load_data_i | input | 64 | Preset bytes, offset k in bits [8k+7:8k] |
| rd_addr_i | input | 3 | Byte offset for the read port |
| rd_data_o | output | 8 | Byte at rd_addr_i |
| window_o | output | 64 | All eight bytes, offset k in bits [8k+7:8k] |
| osc_run_o | output | 1 | Oscillator running flag |

## Verification
A tick or a load sampled at a rising edge shows on window_o and osc_run_o right after that same edge. The bench drives inputs on falling edges and compares against its model on the next falling edge, exactly one register stage later. The read port has no register in its path, so its checks sample shortly after rd_addr_i changes, within the same cycle. A behavioural model updates on each rising edge from the same inputs, and every clock the bench compares the whole window and the run flag against it. Directed checks compare against hand-computed byte patterns.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_REG    = 8;
  localparam int ADDR_W   = $clog2(N_REG);
  localparam int WIN_W    = BYTE_W * N_REG;
  localparam int N_CNT    = 7;   // chained BCD fields: sec..year, century
  localparam int WD_W     = 3;
  localparam int HR_VAL_W = 6;

  localparam int OFS_SEC = 0;
  localparam int OFS_MIN = 1;
  localparam int OFS_HR  = 2;
  localparam int OFS_DAY = 3;
  localparam int OFS_MON = 4;
  localparam int OFS_YR  = 5;
  localparam int OFS_WD  = 6;
  localparam int OFS_CEN = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int cnt_ofs(input int i);
    return (i == N_CNT - 1) ? OFS_CEN : i;
  endfunction

  function automatic byte_t fld_max(input int ofs);
    case (ofs)
      OFS_SEC, OFS_MIN: return 8'h59;
      OFS_HR:           return 8'h23;
      OFS_MON:          return 8'h12;
      OFS_YR, OFS_CEN:  return 8'h99;
      default:          return 8'h31;
    endcase
  endfunction

  function automatic byte_t fld_min(input int ofs);
    return (ofs == OFS_DAY || ofs == OFS_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic byte_t rst_byte(input int ofs);
    case (ofs)
      OFS_HR:           return 8'h80;
      OFS_DAY, OFS_MON: return 8'h01;
      OFS_CEN:          return 8'h20;
      default:          return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] min_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-5:0] tens_inc;
  assign tens_inc = val_i[W-1:4] + 1'b1;

  always_comb begin
    wrap_o = (val_i >= max_i);
    if (wrap_o)                  nxt_o = min_i;
    else if (val_i[3:0] >= 4'd9) nxt_o = {tens_inc, 4'h0};
    else                         nxt_o = val_i + 1'b1;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  byte_t mon_i,
  input  byte_t yr_i,
  output byte_t last_day_o
);
  logic leap;

  // BCD year divisible by 4: even tens -> ones 0/4/8, odd tens -> ones 2/6
  always_comb begin
    if (yr_i[4]) leap = (yr_i[3:0] == 4'd2) || (yr_i[3:0] == 4'd6);
    else         leap = (yr_i[3:0] == 4'd0) || (yr_i[3:0] == 4'd4) || (yr_i[3:0] == 4'd8);
  end

  always_comb begin
    case (mon_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [WIN_W-1:0]  load_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [WIN_W-1:0]  window_o,
  output logic              osc_run_o
);
  byte_t regs_q [N_REG];
  logic  run_q;

  byte_t cur     [N_CNT];
  byte_t nxt     [N_CNT];
  byte_t lim_max [N_CNT];
  logic  wrap    [N_CNT];
  logic  en      [N_CNT];
  byte_t day_max;
  logic  step;
  logic  load_zero;
  logic [WD_W-1:0] wd_nxt;

  assign step      = tick_i & run_q;
  assign load_zero = (load_data_i == '0);

  cal_month_len u_mlen (
    .mon_i      (regs_q[OFS_MON]),
    .yr_i       (regs_q[OFS_YR]),
    .last_day_o (day_max)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_fld
    localparam int OFS = cnt_ofs(i);
    if (OFS == OFS_HR) begin : g_hr
      assign cur[i] = {{(BYTE_W-HR_VAL_W){1'b0}}, regs_q[OFS][HR_VAL_W-1:0]};
    end else begin : g_plain
      assign cur[i] = regs_q[OFS];
    end
    if (OFS == OFS_DAY) begin : g_dmax
      assign lim_max[i] = day_max;
    end else begin : g_cmax
      assign lim_max[i] = fld_max(OFS);
    end
    if (i == 0) begin : g_first
      assign en[i] = step;
    end else begin : g_chain
      assign en[i] = en[i-1] & wrap[i-1];
    end
    cal_bcd_step #(.W(BYTE_W)) u_step (
      .val_i  (cur[i]),
      .max_i  (lim_max[i]),
      .min_i  (fld_min(OFS)),
      .nxt_o  (nxt[i]),
      .wrap_o (wrap[i])
    );
  end

  assign wd_nxt = (regs_q[OFS_WD][WD_W-1:0] >= 3'd6) ? '0 : regs_q[OFS_WD][WD_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_REG; k++) regs_q[k] <= rst_byte(k);
      run_q <= 1'b0;
    end else if (load_i) begin
      for (int k = 0; k < N_REG; k++) regs_q[k] <= load_data_i[k*BYTE_W +: BYTE_W];
      regs_q[OFS_WD] <= {{(BYTE_W-WD_W){1'b0}}, load_data_i[OFS_WD*BYTE_W +: WD_W]};
      if (load_zero) run_q <= 1'b1;
    end else begin
      for (int i = 0; i < N_CNT; i++) begin
        if (en[i]) begin
          if (cnt_ofs(i) == OFS_HR)
            regs_q[OFS_HR] <= {regs_q[OFS_HR][BYTE_W-1:HR_VAL_W], nxt[i][HR_VAL_W-1:0]};
          else
            regs_q[cnt_ofs(i)] <= nxt[i];
        end
      end
      if (en[OFS_DAY]) regs_q[OFS_WD] <= {{(BYTE_W-WD_W){1'b0}}, wd_nxt};
    end
  end

  for (genvar k = 0; k < N_REG; k++) begin : g_win
    assign window_o[k*BYTE_W +: BYTE_W] = regs_q[k];
  end
  assign rd_data_o = regs_q[rd_addr_i];
  assign osc_run_o = run_q;

  p_stopped_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> $stable(window_o));
  p_run_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  p_load_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (window_o[OFS_WD*BYTE_W-1:0] == $past(load_data_i[OFS_WD*BYTE_W-1:0]))
            && (window_o[WIN_W-1:OFS_CEN*BYTE_W] == $past(load_data_i[WIN_W-1:OFS_CEN*BYTE_W]))
            && (regs_q[OFS_WD] == {5'b0, $past(load_data_i[OFS_WD*BYTE_W +: WD_W])}));
  p_sec_digit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (regs_q[OFS_SEC][3:0] <= 4'd9) || $stable(regs_q[OFS_SEC]));
  p_hour_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(regs_q[OFS_HR][BYTE_W-1:HR_VAL_W]));
  p_cen_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(regs_q[OFS_CEN]) || (regs_q[OFS_YR] == 8'h00));
  p_wday_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && regs_q[OFS_WD] <= 8'd6) |=> (regs_q[OFS_WD] <= 8'd6));
endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [63:0] ldata = '0;
  logic [2:0]  raddr = '0;
  logic [7:0]  rdata;
  logic [63:0] win;
  logic        run;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_calendar dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load),
    .load_data_i(ldata), .rd_addr_i(raddr), .rd_data_o(rdata),
    .window_o(win), .osc_run_o(run)
  );

  // behavioural reference model
  logic [7:0] m [8];
  bit mrun;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    logic [3:0] t, o;
    t = 4'(v / 10);
    o = 4'(v % 10);
    return {t, o};
  endfunction
  function automatic logic [63:0] mpack();
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = m[k];
    return r;
  endfunction

  task automatic model_step();
    int v, dim, mo;
    bit c;
    v = b2i(m[0]); c = (v >= 59); m[0] = c ? 8'h00 : i2b(v + 1);
    if (c) begin v = b2i(m[1]); c = (v >= 59); m[1] = c ? 8'h00 : i2b(v + 1); end
    if (c) begin
      v = b2i(m[2] & 8'h3f); c = (v >= 23);
      m[2] = (m[2] & 8'hc0) | (c ? 8'h00 : i2b(v + 1));
    end
    if (c) begin
      mo = b2i(m[4]);
      if (mo == 2) dim = (b2i(m[5]) % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
      else dim = 31;
      m[6] = (m[6] >= 6) ? 8'h00 : m[6] + 8'h01;
      v = b2i(m[3]); c = (v >= dim); m[3] = c ? 8'h01 : i2b(v + 1);
    end
    if (c) begin v = b2i(m[4]); c = (v >= 12); m[4] = c ? 8'h01 : i2b(v + 1); end
    if (c) begin v = b2i(m[5]); c = (v >= 99); m[5] = c ? 8'h00 : i2b(v + 1); end
    if (c) begin v = b2i(m[7]); m[7] = (v >= 99) ? 8'h00 : i2b(v + 1); end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h80; m[3] = 8'h01;
      m[4] = 8'h01; m[5] = 8'h00; m[6] = 8'h00; m[7] = 8'h20;
      mrun = 0;
    end else if (load) begin
      for (int k = 0; k < 8; k++) m[k] = ldata[k*8 +: 8];
      m[6] = {5'b0, ldata[50:48]};
      if (ldata == '0) mrun = 1;
    end else if (tick && mrun) begin
      model_step();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 R5 R6 R7 R8 R9 R10 model window", win, mpack());
      chk("R2 model run flag", {63'b0, run}, {63'b0, mrun});
    end
  end

  task automatic do_load(input logic [63:0] d);
    @(negedge clk); load = 1'b1; ldata = d;
    @(negedge clk); load = 1'b0;
  endtask
  task automatic do_tick(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask
  task automatic roll(input string req, input logic [63:0] from, input logic [63:0] to);
    do_load(from);
    do_tick(1);
    chk(req, win, to);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad + 0);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    chk("R1 reset window", win, 64'h20_00_00_01_01_80_00_00);
    chk("R1 reset run", {63'b0, run}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_tick(3);
    chk("R2 stopped ignores ticks", win, 64'h20_00_00_01_01_80_00_00);

    do_load(64'h19_06_99_12_31_A3_59_58);
    chk("R3 preset copy", win, 64'h19_06_99_12_31_A3_59_58);
    chk("R2 nonzero load keeps stopped", {63'b0, run}, 64'd0);
    do_tick(2);
    chk("R2 stopped after preset", win, 64'h19_06_99_12_31_A3_59_58);

    do_load('0);
    chk("R2 zero load starts", {63'b0, run}, 64'd1);
    chk("R2 zero load window", win, 64'd0);
    do_tick(1);
    chk("R4 second step", win, 64'h01);

    do_load(64'h19_06_99_12_31_A3_59_58);
    chk("R2 run stays set", {63'b0, run}, 64'd1);
    do_tick(1);
    chk("R4 to 59", win, 64'h19_06_99_12_31_A3_59_59);
    do_tick(1);
    chk("R9 R8 R10 R5 century rollover", win, 64'h20_00_00_01_01_80_00_00);

    roll("R7 leap year 00", 64'h20_02_00_02_28_23_59_59, 64'h20_03_00_02_29_00_00_00);
    roll("R7 common year 01", 64'h20_02_01_02_28_23_59_59, 64'h20_03_01_03_01_00_00_00);
    roll("R7 leap year 12", 64'h20_04_12_02_28_23_59_59, 64'h20_05_12_02_29_00_00_00);
    roll("R7 Feb 29 end", 64'h20_04_12_02_29_23_59_59, 64'h20_05_12_03_01_00_00_00);
    roll("R6 April 30", 64'h20_01_24_04_30_23_59_59, 64'h20_02_24_05_01_00_00_00);
    roll("R6 January 30", 64'h20_01_24_01_30_23_59_59, 64'h20_02_24_01_31_00_00_00);
    roll("R5 R10 hour bits 7:6 kept", 64'h20_06_24_06_30_E3_59_59, 64'h20_00_24_07_01_C0_00_00);
    roll("R4 minute out of range", 64'h20_00_24_07_01_80_75_59, 64'h20_00_24_07_01_81_00_00);
    roll("R9 century BCD", 64'h19_02_99_12_31_23_59_59, 64'h20_03_00_01_01_00_00_00);

    do_load(64'h20_FF_24_07_01_80_00_00);
    chk("R3 weekday mask", win, 64'h20_07_24_07_01_80_00_00);
    @(negedge clk); load = 1'b1; tick = 1'b1; ldata = 64'h20_03_33_05_15_92_30_10;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    chk("R3 load beats tick", win, 64'h20_03_33_05_15_92_30_10);

    r = 64'h20_03_33_05_15_92_30_10;
    for (int k = 0; k < 8; k++) begin
      raddr = 3'(k);
      #1;
      chk("R11 read port", {56'b0, rdata}, {56'b0, r[k*8 +: 8]});
    end

    for (int n = 0; n < 40; n++) begin
      r[7:0]   = i2b(50 + $urandom % 10);
      r[15:8]  = i2b(55 + $urandom % 5);
      r[23:16] = i2b(20 + $urandom % 4) | (($urandom % 2) ? 8'h80 : 8'h00);
      r[31:24] = i2b(25 + $urandom % 7);
      r[39:32] = i2b(1 + $urandom % 12);
      r[47:40] = (n % 4 == 0) ? i2b(96 + $urandom % 4) : i2b($urandom % 100);
      r[55:48] = 8'($urandom % 7);
      r[63:56] = ($urandom % 2) ? 8'h19 : 8'h20;
      do_load(r);
      for (int j = 0; j < 150; j++) begin
        @(negedge clk); tick = ($urandom % 4) != 0;
      end
      @(negedge clk); tick = 1'b0;
    end

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule